// File: doc/BRIEF.md
# Calendar Real-Time Clock with Alarm

This block keeps wall-clock time and date from a free-running reference clock. A sub-second counter runs on every reference cycle. When it reaches a programmed ratio it wraps, and that wrap is the one-second tick. The tick drives a binary calendar: second, minute, hour, weekday, day of month, month, year within the century, and century. Month lengths follow the Gregorian leap-year rule.

Software loads the calendar and the alarm through a byte-wide write port, and reads the live time directly from output ports. Any calendar write restarts the sub-second counter, so the new time begins on a whole second. An alarm compares six fields (year down to second) against the live calendar. Periodic events fire when the second, minute, hour or day rolls over. Each event has its own enable and a sticky status bit that is cleared by writing 1. An interrupt line is raised while any status bit is set. Reset clears all state to zero.

Top module: `rtc_calendar`

## Requirements
- R1: `subSec` increments once per reference cycle. When it has reached `divRatio`-1 it returns to 0 on the next cycle, and the second advances on that same edge. A `divRatio` of 0 behaves as 1.
- R2: A write with `wrAddr` 0..7 loads second, minute, hour, weekday, day, month, year or century respectively from the low bits of `wrData`. The same edge forces `subSec` to 0.
- R3: The second wraps from 59 to 0 and carries into the minute. The minute wraps from 59 to 0 and carries into the hour. The hour wraps from 23 to 0 and produces a day rollover.
- R4: A day rollover moves the day back to 1 once the day has reached the month length (30 for months 4, 6, 9, 11; 31 otherwise except February) and advances the month. Month 12 wraps to 1 and advances the year. Year 99 wraps to 0 and increments the century.
- R5: February has 29 days when the year field is a multiple of 4, except when the year field is 0 and the century is not a multiple of 4; otherwise February has 28 days.
- R6: The weekday advances on every day rollover and wraps from 6 to 0.
- R7: Write address 14 holds interrupt enables in bits [4:0] (bit0 second, bit1 minute, bit2 hour, bit3 day, bit4 alarm). A rollover event sets its status bit on the same edge that updates the calendar, and only if its enable is 1.
- R8: Write addresses 8..13 load the alarm second, minute, hour, day, month and year. Status bit4 is set on the edge after the calendar first comes to equal all six alarm fields, and is not set again while the match persists.
- R9: Status bits stay set until a write to address 15 with a 1 in that bit position clears them. A set and a clear in the same cycle leave the bit set. `irq` is high while any status bit is 1.
- R10: Reset clears the calendar, `subSec`, alarm fields, enables and status to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Active-low synchronous reset |
| divRatio | input | DIV_W | Reference cycles per second |
| wrEn | input | 1 | Write strobe |
| wrAddr | input | 4 | Write address |
| wrData | input | 8 | Write data |
| secOut | output | 6 | Second |
| minOut | output | 6 | Minute |
| hourOut | output | 5 | Hour |
| wdayOut | output | 3 | Weekday 0..6 |
| dayOut | output | 5 | Day of month |
| monOut | output | 4 | Month |
| yearOut | output | 7 | Year within century |
| centOut | output | 8 | Century |
| subSec | output | DIV_W | Sub-second count |
| irqStatus | output | 5 | Sticky event status |
| irq | output | 1 | Interrupt request |

## Verification
The bench drives the full cascade from 23:59:59 on the last day of a century into the next century. A carry-chain slip would leave one field stale, and a wrong weekday wrap would show 7. February ends are tested in a plain leap year, a non-leap year, a century year divisible by 400 and one that is not. A flawed leap rule shows a day 29 where March 1 is expected, or the reverse. The alarm is placed exactly on a month boundary. The bench checks that its status appears one edge after the match and does not return after clearing while the match holds. A level-based alarm would re-fire immediately. Divider checks catch an off-by-one second length and a missed sub-second restart on writes.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;
  localparam int NUM_IRQ = 5;

  typedef struct packed {
    logic       tick;
    logic       wrCal;
    logic [2:0] field;
    logic [7:0] data;
  } calCmd_t;

  typedef struct packed {
    logic day;
    logic hour;
    logic min;
    logic sec;
  } rollEvt_t;

  function automatic logic [4:0] monthLen(input logic [3:0] mon, input logic leap);
    case (mon)
      4'd2:                      monthLen = leap ? 5'd29 : 5'd28;
      4'd4, 4'd6, 4'd9, 4'd11:   monthLen = 5'd30;
      default:                   monthLen = 5'd31;
    endcase
  endfunction
endpackage

// File: rtl/rtc_cal_datapath.sv
module rtc_cal_datapath
  import rtc_cal_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  calCmd_t    cmd,
  output rollEvt_t   evt,
  output logic [5:0] secQ,
  output logic [5:0] minQ,
  output logic [4:0] hourQ,
  output logic [2:0] wdayQ,
  output logic [4:0] dayQ,
  output logic [3:0] monQ,
  output logic [6:0] yearQ,
  output logic [7:0] centQ
);
  logic secWrap, minWrap, hourWrap, dayEnd, monWrap, yearWrap, isLeap;

  always_comb begin
    isLeap   = (yearQ[1:0] == 2'd0) && ((yearQ != 7'd0) || (centQ[1:0] == 2'd0));
    secWrap  = secQ >= 6'd59;
    minWrap  = minQ >= 6'd59;
    hourWrap = hourQ >= 5'd23;
    dayEnd   = dayQ >= monthLen(monQ, isLeap);
    monWrap  = monQ >= 4'd12;
    yearWrap = yearQ >= 7'd99;
    evt.sec  = cmd.tick;
    evt.min  = cmd.tick & secWrap;
    evt.hour = evt.min & minWrap;
    evt.day  = evt.hour & hourWrap;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      secQ <= '0; minQ <= '0; hourQ <= '0; wdayQ <= '0;
      dayQ <= '0; monQ <= '0; yearQ <= '0; centQ <= '0;
    end else if (cmd.wrCal) begin
      case (cmd.field)
        3'd0: secQ  <= cmd.data[5:0];
        3'd1: minQ  <= cmd.data[5:0];
        3'd2: hourQ <= cmd.data[4:0];
        3'd3: wdayQ <= cmd.data[2:0];
        3'd4: dayQ  <= cmd.data[4:0];
        3'd5: monQ  <= cmd.data[3:0];
        3'd6: yearQ <= cmd.data[6:0];
        default: centQ <= cmd.data;
      endcase
    end else if (cmd.tick) begin
      secQ <= secWrap ? 6'd0 : secQ + 6'd1;
      if (evt.min)  minQ  <= minWrap ? 6'd0 : minQ + 6'd1;
      if (evt.hour) hourQ <= hourWrap ? 5'd0 : hourQ + 5'd1;
      if (evt.day) begin
        wdayQ <= (wdayQ >= 3'd6) ? 3'd0 : wdayQ + 3'd1;
        if (dayEnd) begin
          dayQ <= 5'd1;
          if (monWrap) begin
            monQ <= 4'd1;
            if (yearWrap) begin
              yearQ <= 7'd0;
              centQ <= centQ + 8'd1;
            end else begin
              yearQ <= yearQ + 7'd1;
            end
          end else begin
            monQ <= monQ + 4'd1;
          end
        end else begin
          dayQ <= dayQ + 5'd1;
        end
      end
    end
  end
endmodule

// File: rtl/rtc_cal_ctrl.sv
module rtc_cal_ctrl
  import rtc_cal_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [DIV_W-1:0]   divRatio,
  input  logic               wrEn,
  input  logic [3:0]         wrAddr,
  input  logic [7:0]         wrData,
  input  rollEvt_t           evt,
  input  logic [7:0]         curFields [6],
  output calCmd_t            cmd,
  output logic [DIV_W-1:0]   subSecQ,
  output logic [NUM_IRQ-1:0] statusQ,
  output logic               irq
);
  localparam int ALM_N = 6;
  localparam logic [3:0] ALM_BASE = 4'd8;
  localparam logic [3:0] EN_ADDR  = 4'd14;
  localparam logic [3:0] CLR_ADDR = 4'd15;

  logic [DIV_W-1:0]   lastCnt;
  logic [7:0]         alarmQ [ALM_N];
  logic [NUM_IRQ-1:0] enQ, setVec, clrVec;
  logic [ALM_N-1:0]   fieldEq;
  logic               matchNow, matchQ;

  always_comb begin
    lastCnt   = (divRatio == '0) ? '0 : divRatio - 1'b1;
    cmd.wrCal = wrEn && !wrAddr[3];
    cmd.field = wrAddr[2:0];
    cmd.data  = wrData;
    cmd.tick  = !cmd.wrCal && (subSecQ >= lastCnt);
  end

  for (genvar i = 0; i < ALM_N; i++) begin : g_alm
    always_ff @(posedge clk) begin
      if (!rstN) alarmQ[i] <= '0;
      else if (wrEn && wrAddr == ALM_BASE + 4'(i)) alarmQ[i] <= wrData;
    end
    assign fieldEq[i] = (alarmQ[i] == curFields[i]);
  end

  assign matchNow = &fieldEq;

  always_comb begin
    setVec = {matchNow & ~matchQ, evt.day, evt.hour, evt.min, evt.sec} & enQ;
    clrVec = (wrEn && wrAddr == CLR_ADDR) ? wrData[NUM_IRQ-1:0] : '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      subSecQ <= '0;
      enQ     <= '0;
      statusQ <= '0;
      matchQ  <= 1'b0;
    end else begin
      if (cmd.wrCal || cmd.tick) subSecQ <= '0;
      else                       subSecQ <= subSecQ + 1'b1;
      if (wrEn && wrAddr == EN_ADDR) enQ <= wrData[NUM_IRQ-1:0];
      statusQ <= (statusQ & ~clrVec) | setVec;
      matchQ  <= matchNow;
    end
  end

  assign irq = |statusQ;
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_cal_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [DIV_W-1:0] divRatio,
  input  logic             wrEn,
  input  logic [3:0]       wrAddr,
  input  logic [7:0]       wrData,
  output logic [5:0]       secOut,
  output logic [5:0]       minOut,
  output logic [4:0]       hourOut,
  output logic [2:0]       wdayOut,
  output logic [4:0]       dayOut,
  output logic [3:0]       monOut,
  output logic [6:0]       yearOut,
  output logic [7:0]       centOut,
  output logic [DIV_W-1:0] subSec,
  output logic [4:0]       irqStatus,
  output logic             irq
);
  calCmd_t  cmd;
  rollEvt_t evt;
  logic [7:0] curFields [6];

  assign curFields[0] = {2'b0, secOut};
  assign curFields[1] = {2'b0, minOut};
  assign curFields[2] = {3'b0, hourOut};
  assign curFields[3] = {3'b0, dayOut};
  assign curFields[4] = {4'b0, monOut};
  assign curFields[5] = {1'b0, yearOut};

  rtc_cal_ctrl #(.DIV_W(DIV_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .divRatio(divRatio), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .evt(evt), .curFields(curFields), .cmd(cmd),
    .subSecQ(subSec), .statusQ(irqStatus), .irq(irq)
  );

  rtc_cal_datapath u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .evt(evt),
    .secQ(secOut), .minQ(minOut), .hourQ(hourOut), .wdayQ(wdayOut),
    .dayQ(dayOut), .monQ(monOut), .yearQ(yearOut), .centQ(centOut)
  );
endmodule

// File: rtl/rtc_cal_checker.sv
module rtc_cal_checker #(
  parameter int DIV_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic [DIV_W-1:0] divRatio,
  input logic             wrEn,
  input logic [3:0]       wrAddr,
  input logic [5:0]       secOut,
  input logic [DIV_W-1:0] subSec,
  input logic [4:0]       irqStatus
);
  logic calWr, midSecond;
  assign calWr     = wrEn && !wrAddr[3];
  assign midSecond = ({1'b0, subSec} + 1'b1) < {1'b0, divRatio};

  AST_SUBSEC_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    calWr |=> subSec == '0); // R2
  AST_SUBSEC_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (!calWr && midSecond) |=> subSec == $past(subSec) + 1'b1); // R1
  AST_SEC_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!calWr && midSecond) |=> $stable(secOut)); // R1
  AST_SEC_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (!calWr && !midSecond && secOut == 6'd59) |=> secOut == 6'd0); // R3
  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    !(wrEn && wrAddr == 4'd15) |=> (($past(irqStatus) & ~irqStatus) == 5'd0)); // R9
endmodule

bind rtc_calendar rtc_cal_checker #(.DIV_W(DIV_W)) u_rtc_chk (
  .clk(clk), .rstN(rstN), .divRatio(divRatio), .wrEn(wrEn), .wrAddr(wrAddr),
  .secOut(secOut), .subSec(subSec), .irqStatus(irqStatus)
);

// File: tb/rtc_calendar_bench.sv
module rtc_calendar_bench;
  localparam int DIV_W = 16;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic [DIV_W-1:0] divRatio = 16'd5;
  logic             wrEn = 1'b0;
  logic [3:0]       wrAddr = '0;
  logic [7:0]       wrData = '0;
  logic [5:0] secOut, minOut;
  logic [4:0] hourOut, dayOut;
  logic [2:0] wdayOut;
  logic [3:0] monOut;
  logic [6:0] yearOut;
  logic [7:0] centOut;
  logic [DIV_W-1:0] subSec;
  logic [4:0] irqStatus;
  logic irq;

  int nChecks = 0;
  int nFails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  rtc_calendar #(.DIV_W(DIV_W)) u_rtc_calendar (
    .clk(clk), .rstN(rstN), .divRatio(divRatio), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .secOut(secOut), .minOut(minOut), .hourOut(hourOut),
    .wdayOut(wdayOut), .dayOut(dayOut), .monOut(monOut), .yearOut(yearOut),
    .centOut(centOut), .subSec(subSec), .irqStatus(irqStatus), .irq(irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic writeReg(input int addr, input int data);
    wrEn = 1'b1; wrAddr = 4'(addr); wrData = 8'(data);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setTime(input int cent, input int yr, input int mon, input int day,
                         input int hr, input int mn, input int sc);
    writeReg(7, cent); writeReg(6, yr); writeReg(5, mon); writeReg(4, day);
    writeReg(2, hr);   writeReg(1, mn); writeReg(0, sc);
  endtask

  task automatic testReset();
    chk("R10 sec", secOut, 0); chk("R10 day", dayOut, 0); chk("R10 cent", centOut, 0);
    chk("R10 subSec", subSec, 0); chk("R10 status", irqStatus, 0); chk("R10 irq", irq, 0);
  endtask

  task automatic testDivider();
    divRatio = 16'd5;
    writeReg(0, 10);
    chk("R2 subSec restart", subSec, 0); chk("R2 sec load", secOut, 10);
    waitCyc(4);
    chk("R1 subSec count", subSec, 4); chk("R1 sec held", secOut, 10);
    waitCyc(1);
    chk("R1 subSec wrap", subSec, 0); chk("R1 sec step", secOut, 11);
    divRatio = 16'd0;
    writeReg(0, 0);
    waitCyc(3);
    chk("R1 ratio zero", secOut, 3);
    divRatio = 16'd100;
    writeReg(0, 0);
  endtask

  task automatic testCascade();
    writeReg(14, 8'h0F);
    writeReg(15, 8'h1F);
    divRatio = 16'd3;
    writeReg(3, 6);
    setTime(19, 99, 12, 31, 23, 59, 59);
    waitCyc(2);
    chk("R3 before tick", secOut, 59); chk("R7 no early status", irqStatus, 0);
    waitCyc(1);
    divRatio = 16'd100;
    chk("R3 sec", secOut, 0); chk("R3 min", minOut, 0); chk("R3 hour", hourOut, 0);
    chk("R4 day", dayOut, 1); chk("R4 month", monOut, 1);
    chk("R4 year", yearOut, 0); chk("R4 century", centOut, 20);
    chk("R6 weekday wrap", wdayOut, 0);
    chk("R7 all periodic", irqStatus, 5'h0F); chk("R9 irq", irq, 1);
    writeReg(15, 8'h01);
    chk("R9 partial clear", irqStatus, 5'h0E);
    writeReg(15, 8'h0E);
    chk("R9 full clear", irqStatus, 0); chk("R9 irq low", irq, 0);
  endtask

  task automatic testMask();
    writeReg(14, 0);
    divRatio = 16'd2;
    writeReg(0, 5);
    waitCyc(2);
    chk("R7 tick happened", secOut, 6); chk("R7 masked", irqStatus, 0);
  endtask

  task automatic dayRoll(input string req, input int cent, input int yr, input int mon,
                         input int day, input int expDay, input int expMon);
    divRatio = 16'd2;
    writeReg(3, 2);
    setTime(cent, yr, mon, day, 23, 59, 59);
    waitCyc(2);
    chk(req, dayOut, expDay);
    chk(req, monOut, expMon);
  endtask

  task automatic testLeap();
    dayRoll("R5 leap 2024", 20, 24, 2, 28, 29, 2);
    dayRoll("R5 common 2023", 20, 23, 2, 28, 1, 3);
    dayRoll("R5 year 2000", 20, 0, 2, 28, 29, 2);
    dayRoll("R5 year 1900", 19, 0, 2, 28, 1, 3);
    dayRoll("R5 Feb 29 end", 20, 24, 2, 29, 1, 3);
    dayRoll("R4 30-day month", 20, 24, 4, 30, 1, 5);
    dayRoll("R4 mid month", 20, 24, 5, 30, 31, 5);
    chk("R6 weekday step", wdayOut, 3);
  endtask

  task automatic testAlarm();
    divRatio = 16'd100;
    writeReg(14, 8'h10);
    writeReg(15, 8'h1F);
    writeReg(8, 0); writeReg(9, 0); writeReg(10, 0);
    writeReg(11, 1); writeReg(12, 3); writeReg(13, 24);
    divRatio = 16'd2;
    setTime(20, 24, 2, 29, 23, 59, 59);
    chk("R8 no alarm before", irqStatus, 0);
    waitCyc(2);
    chk("R8 time reached", monOut, 3);
    chk("R8 status lags match", irqStatus, 0);
    waitCyc(1);
    divRatio = 16'd50;
    chk("R8 alarm set", irqStatus, 5'h10); chk("R9 irq alarm", irq, 1);
    writeReg(15, 8'h10);
    chk("R9 alarm cleared", irqStatus, 0);
    waitCyc(3);
    chk("R8 no refire while matched", irqStatus, 0);
  endtask

  initial begin
    waitCyc(3);
    testReset();
    rstN = 1'b1;
    testDivider();
    testCascade();
    testMask();
    testLeap();
    testAlarm();
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 100000) begin
      @(negedge clk);
      cyc++;
    end
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule